// File: doc/BRIEF.md
# Peripheral Device Control Interface

This block is the device-side control logic for one peripheral attached to a shared processor I/O bus. Each I/O instruction arrives as a small decoded bundle: a valid strobe, a 6-bit device code, a transfer kind and a 2-bit control field. The block reacts only when the code on the bus equals its own parameterised code. It keeps a Busy/Done flag pair that describes the state of the peripheral. It holds three data buffers of independent widths that the processor can write or read back. It applies start, clear and pulse controls, and it answers four skip tests on its flags.

A single-cycle `work_done_i` strobe stands in for the peripheral mechanism. When it arrives while the device is busy, the device moves to the done state. Done raises an interrupt request unless the device's interrupt-disable flag is set. A broadcast mask strobe loads that flag from one chosen bit of the data word. On an interrupt acknowledge, the priority chain decides which device answers. A device that receives priority and has a request places its code on the read data lines. A device with no request passes priority on to the next device. A separate I/O reset returns the flags of every device to idle.

Top module: `dev_ioctl`

## Requirements
- R1: A synchronous `rst` clears every register, including the buffers and the registered outputs. A synchronous `io_reset_i` clears Busy, Done, interrupt-disable and `irq_o` on the next edge, and takes precedence over every other flag update in that cycle.
- R2: An instruction takes effect only when `iop_valid_i` is 1 and `iop_dev_i` equals `DEV_CODE`. Code 0 and code 63 (all ones) never select the device, whatever the parameter value.
- R3: Control field 1 (start) on a selected non-skip instruction leaves Busy=1 and Done=0 after the next edge.
- R4: Control field 2 (clear) leaves Busy=0 and Done=0. Control field 0 changes neither flag.
- R5: Control field 3 (pulse) drives `ctl_pulse_o` high for the cycle after the instruction and leaves the flags unchanged.
- R6: `work_done_i` while Busy=1 gives Busy=0 and Done=1. While Busy=0 it has no effect. If a selected bus control arrives in the same cycle, the bus control decides the result.
- R7: Busy and Done are never both 1.
- R8: `irq_o` equals Done AND NOT interrupt-disable, and it is updated on the same edge as those flags.
- R9: `mask_i` loads interrupt-disable from `wdata_i[MASK_BIT]`. A value of 1 blocks the request and a value of 0 allows it.
- R10: Transfer codes are: 0 none, 1 read A, 2 write A, 3 read B, 4 write B, 5 read C, 6 write C, 7 skip. A write loads the buffer from the low bits of `wdata_i`. A read presents the buffer, zero-extended, on `rd_data_o` in the next cycle. In any other cycle `rd_data_o` is 0. The control field of a transfer instruction is applied in the same cycle.
- R11: On transfer code 7 the control field selects a test: 0 Busy=1, 1 Busy=0, 2 Done=1, 3 Done=0. `skip_o` shows the result in the next cycle, and no control action is applied.
- R12: When `intack_i` is 1, `pri_in_i` is 1 and `irq_o` is 1, `rd_data_o` carries `DEV_CODE` in the next cycle, taking precedence over a read. `pri_out_o` equals `pri_in_i` AND NOT `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_reset_i | input | 1 | Bus-wide I/O reset of the flags |
| iop_valid_i | input | 1 | An I/O instruction is on the bus |
| iop_dev_i | input | CODE_W | Device code field |
| iop_xfer_i | input | 3 | Transfer kind |
| iop_ctl_i | input | 2 | Control field or skip test |
| wdata_i | input | DATA_W | Data lines from the processor |
| mask_i | input | 1 | Broadcast interrupt-mask load |
| intack_i | input | 1 | Interrupt acknowledge |
| pri_in_i | input | 1 | Priority from the device nearer the processor |
| pri_out_o | output | 1 | Priority to the device further down the chain |
| work_done_i | input | 1 | Mechanism finished a unit of data |
| rd_data_o | output | DATA_W | Read data or acknowledge code, zero when idle |
| skip_o | output | 1 | Skip-test result |
| ctl_pulse_o | output | 1 | Special control line pulse |
| busy_o | output | 1 | Busy flag |
| done_o | output | 1 | Done flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a collision in a single cycle. In it, `work_done_i` arrives while the device is busy, and a selected clear or start instruction arrives in the same cycle, possibly together with an I/O reset or a mask load. The device must be busy beforehand, so the random stimulus issues starts often, and it raises `work_done_i` and the control strobes independently each cycle, so these collisions recur many times. Directed cases also reach this situation on purpose. They also cover an acknowledge that coincides with a read, and the reserved codes 0 and 63.

// File: rtl/devio_pkg.sv
package devio_pkg;
  typedef enum logic [2:0] {
    XF_NONE  = 3'd0,
    XF_IN_A  = 3'd1,
    XF_OUT_A = 3'd2,
    XF_IN_B  = 3'd3,
    XF_OUT_B = 3'd4,
    XF_IN_C  = 3'd5,
    XF_OUT_C = 3'd6,
    XF_SKIP  = 3'd7
  } xfer_e;

  typedef enum logic [1:0] {
    CT_NONE  = 2'd0,
    CT_START = 2'd1,
    CT_CLEAR = 2'd2,
    CT_PULSE = 2'd3
  } ctl_e;

  localparam int NUM_BUFS = 3;
endpackage

// File: rtl/dev_decode.sv
module dev_decode #(
  parameter int CODE_W = 6,
  parameter logic [CODE_W-1:0] DEV_CODE = 6'd17
) (
  input  logic              valid_i,
  input  logic [CODE_W-1:0] dev_i,
  input  logic [2:0]        xfer_i,
  output logic              ctl_en_o,
  output logic              skip_en_o,
  output logic              rd_en_o,
  output logic              wr_en_o,
  output logic [1:0]        idx_o
);
  import devio_pkg::*;
  localparam logic [CODE_W-1:0] RESV = {CODE_W{1'b1}};

  logic  sel;
  xfer_e xf;

  always_comb begin
    xf        = xfer_e'(xfer_i);
    sel       = valid_i && (dev_i == DEV_CODE) && (dev_i != '0) && (dev_i != RESV);
    skip_en_o = sel && (xf == XF_SKIP);
    ctl_en_o  = sel && (xf != XF_SKIP);
    rd_en_o   = sel && (xf == XF_IN_A || xf == XF_IN_B || xf == XF_IN_C);
    wr_en_o   = sel && (xf == XF_OUT_A || xf == XF_OUT_B || xf == XF_OUT_C);
    idx_o     = 2'((xfer_i - 3'd1) >> 1);
  end
endmodule

// File: rtl/dev_flags.sv
module dev_flags (
  input  logic       clk,
  input  logic       rst,
  input  logic       io_reset_i,
  input  logic       ctl_en_i,
  input  logic [1:0] ctl_i,
  input  logic       work_done_i,
  input  logic       mask_we_i,
  input  logic       mask_bit_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       dis_o,
  output logic       irq_o,
  output logic       pulse_o
);
  import devio_pkg::*;

  logic busy_q, done_q, dis_q, irq_q, pulse_q;
  logic busy_n, done_n, dis_n;

  always_comb begin
    busy_n = busy_q;
    done_n = done_q;
    dis_n  = dis_q;
    // mechanism completion first, so a bus control in the same cycle overrides it
    if (work_done_i && busy_q) begin
      busy_n = 1'b0;
      done_n = 1'b1;
    end
    if (ctl_en_i) begin
      case (ctl_e'(ctl_i))
        CT_START: begin busy_n = 1'b1; done_n = 1'b0; end
        CT_CLEAR: begin busy_n = 1'b0; done_n = 1'b0; end
        default: ;
      endcase
    end
    if (mask_we_i) dis_n = mask_bit_i;
    if (io_reset_i) begin
      busy_n = 1'b0;
      done_n = 1'b0;
      dis_n  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      dis_q   <= 1'b0;
      irq_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      busy_q  <= busy_n;
      done_q  <= done_n;
      dis_q   <= dis_n;
      irq_q   <= done_n & ~dis_n;
      pulse_q <= ctl_en_i && (ctl_e'(ctl_i) == CT_PULSE);
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign dis_o   = dis_q;
  assign irq_o   = irq_q;
  assign pulse_o = pulse_q;
endmodule

// File: rtl/dev_bufs.sv
module dev_bufs #(
  parameter int DATA_W = 16,
  parameter int A_W    = 16,
  parameter int B_W    = 8,
  parameter int C_W    = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [1:0]        idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  import devio_pkg::*;

  logic [DATA_W-1:0] ext [NUM_BUFS];

  for (genvar i = 0; i < NUM_BUFS; i++) begin : g_buf
    localparam int W = (i == 0) ? A_W : (i == 1) ? B_W : C_W;
    logic [W-1:0] q;

    always_ff @(posedge clk) begin
      if (rst)                                 q <= '0;
      else if (wr_en_i && idx_i == 2'(i))      q <= wdata_i[W-1:0];
    end

    always_comb begin
      ext[i]        = '0;
      ext[i][W-1:0] = q;
    end
  end

  always_comb begin
    case (idx_i)
      2'd0:    rdata_o = ext[0];
      2'd1:    rdata_o = ext[1];
      2'd2:    rdata_o = ext[2];
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dev_ioctl.sv
module dev_ioctl #(
  parameter int DATA_W   = 16,
  parameter int CODE_W   = 6,
  parameter logic [CODE_W-1:0] DEV_CODE = 6'd17,
  parameter int MASK_BIT = 4,
  parameter int A_W      = 16,
  parameter int B_W      = 8,
  parameter int C_W      = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_reset_i,
  input  logic              iop_valid_i,
  input  logic [CODE_W-1:0] iop_dev_i,
  input  logic [2:0]        iop_xfer_i,
  input  logic [1:0]        iop_ctl_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              mask_i,
  input  logic              intack_i,
  input  logic              pri_in_i,
  output logic              pri_out_o,
  input  logic              work_done_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              skip_o,
  output logic              ctl_pulse_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] CODE_EXT = DATA_W'(DEV_CODE);

  logic ctl_en, skip_en, rd_en, wr_en;
  logic [1:0] idx;
  logic busy, done, dis, irq, pulse;
  logic [DATA_W-1:0] buf_rd;
  logic [DATA_W-1:0] rd_q;
  logic skip_q, test;

  dev_decode #(.CODE_W(CODE_W), .DEV_CODE(DEV_CODE)) u_dec (
    .valid_i(iop_valid_i), .dev_i(iop_dev_i), .xfer_i(iop_xfer_i),
    .ctl_en_o(ctl_en), .skip_en_o(skip_en), .rd_en_o(rd_en),
    .wr_en_o(wr_en), .idx_o(idx)
  );

  dev_flags u_flags (
    .clk(clk), .rst(rst), .io_reset_i(io_reset_i),
    .ctl_en_i(ctl_en), .ctl_i(iop_ctl_i), .work_done_i(work_done_i),
    .mask_we_i(mask_i), .mask_bit_i(wdata_i[MASK_BIT]),
    .busy_o(busy), .done_o(done), .dis_o(dis), .irq_o(irq), .pulse_o(pulse)
  );

  dev_bufs #(.DATA_W(DATA_W), .A_W(A_W), .B_W(B_W), .C_W(C_W)) u_bufs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .idx_i(idx),
    .wdata_i(wdata_i), .rdata_o(buf_rd)
  );

  always_comb begin
    case (iop_ctl_i)
      2'd0:    test = busy;
      2'd1:    test = ~busy;
      2'd2:    test = done;
      default: test = ~done;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q   <= '0;
      skip_q <= 1'b0;
    end else begin
      if (intack_i && pri_in_i && irq) rd_q <= CODE_EXT;
      else if (rd_en)                  rd_q <= buf_rd;
      else                             rd_q <= '0;
      skip_q <= skip_en && test;
    end
  end

  assign pri_out_o   = pri_in_i & ~irq;
  assign rd_data_o   = rd_q;
  assign skip_o      = skip_q;
  assign ctl_pulse_o = pulse;
  assign busy_o      = busy;
  assign done_o      = done;
  assign irq_o       = irq;

  logic unused_dis;
  assign unused_dis = dis;
endmodule

// File: rtl/dev_ioctl_chk.sv
module dev_ioctl_chk #(
  parameter int CODE_W = 6,
  parameter logic [CODE_W-1:0] DEV_CODE = 6'd17
) (
  input logic              clk,
  input logic              rst,
  input logic              io_reset_i,
  input logic              iop_valid_i,
  input logic [CODE_W-1:0] iop_dev_i,
  input logic [2:0]        iop_xfer_i,
  input logic [1:0]        iop_ctl_i,
  input logic              pri_out_o,
  input logic              skip_o,
  input logic              ctl_pulse_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              irq_o
);
  AST_IORESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    ($past(io_reset_i) && $past(!rst)) |-> (!busy_o && !done_o && !irq_o)); // R1

  AST_FOREIGN_CODE: assert property (@(posedge clk) disable iff (rst)
    ($past(iop_dev_i != DEV_CODE) && $past(!rst)) |-> (!skip_o && !ctl_pulse_o)); // R2

  AST_START_TAKES: assert property (@(posedge clk) disable iff (rst)
    ($past(iop_valid_i && iop_dev_i == DEV_CODE && iop_xfer_i != 3'd7 && iop_ctl_i == 2'd1
           && !io_reset_i) && $past(!rst)) |-> (busy_o && !done_o)); // R3

  AST_PULSE_SELECTED: assert property (@(posedge clk) disable iff (rst)
    ctl_pulse_o |-> $past(iop_valid_i && iop_dev_i == DEV_CODE && iop_ctl_i == 2'd3)); // R5

  AST_DONE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(busy_o)); // R6

  AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o)); // R7

  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> done_o); // R8

  AST_SKIP_SELECTED: assert property (@(posedge clk) disable iff (rst)
    skip_o |-> $past(iop_valid_i && iop_xfer_i == 3'd7)); // R11

  AST_HOLD_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> !pri_out_o); // R12
endmodule

bind dev_ioctl dev_ioctl_chk #(.CODE_W(CODE_W), .DEV_CODE(DEV_CODE)) u_chk (
  .clk(clk), .rst(rst), .io_reset_i(io_reset_i), .iop_valid_i(iop_valid_i),
  .iop_dev_i(iop_dev_i), .iop_xfer_i(iop_xfer_i), .iop_ctl_i(iop_ctl_i),
  .pri_out_o(pri_out_o), .skip_o(skip_o), .ctl_pulse_o(ctl_pulse_o),
  .busy_o(busy_o), .done_o(done_o), .irq_o(irq_o)
);

// File: tb/tb_dev_ioctl.sv
module tb_dev_ioctl;
  localparam int DW = 16;
  localparam int CW = 6;
  localparam logic [CW-1:0] CODE = 6'd17;
  localparam int MB = 4;
  localparam int WA = 16, WB = 8, WC = 12;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, iores, iv, mask, iack, pin, wd;
  logic [CW-1:0] idev;
  logic [2:0] xfer;
  logic [1:0] ctl;
  logic [DW-1:0] wdata;
  logic pout, skip, pulse, busy, done, irq;
  logic [DW-1:0] rdata;

  dev_ioctl #(.DATA_W(DW), .CODE_W(CW), .DEV_CODE(CODE), .MASK_BIT(MB),
              .A_W(WA), .B_W(WB), .C_W(WC)) dut (
    .clk(clk), .rst(rst), .io_reset_i(iores), .iop_valid_i(iv), .iop_dev_i(idev),
    .iop_xfer_i(xfer), .iop_ctl_i(ctl), .wdata_i(wdata), .mask_i(mask),
    .intack_i(iack), .pri_in_i(pin), .pri_out_o(pout), .work_done_i(wd),
    .rd_data_o(rdata), .skip_o(skip), .ctl_pulse_o(pulse),
    .busy_o(busy), .done_o(done), .irq_o(irq)
  );

  int n_chk = 0, n_bad = 0;
  logic m_busy, m_done, m_dis, m_irq, m_skip, m_pulse;
  logic [DW-1:0] m_a, m_b, m_c, m_rd;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] zx(logic [DW-1:0] v, int w);
    logic [DW-1:0] m;
    m = (w >= DW) ? '1 : ((DW'(1) << w) - 1);
    return v & m;
  endfunction

  function automatic logic test_of(logic b, logic d, logic [1:0] c);
    case (c)
      2'd0: return b;
      2'd1: return !b;
      2'd2: return d;
      default: return !d;
    endcase
  endfunction

  task automatic model();
    logic sel, b, d, s;
    sel = iv && idev == CODE;
    if (rst) begin
      {m_busy, m_done, m_dis, m_irq, m_skip, m_pulse} = '0;
      m_a = '0; m_b = '0; m_c = '0; m_rd = '0;
      return;
    end
    if (iack && pin && m_irq) m_rd = DW'(CODE);
    else if (sel && xfer == 3'd1) m_rd = m_a;
    else if (sel && xfer == 3'd3) m_rd = m_b;
    else if (sel && xfer == 3'd5) m_rd = m_c;
    else m_rd = '0;
    m_skip  = sel && xfer == 3'd7 && test_of(m_busy, m_done, ctl);
    m_pulse = sel && xfer != 3'd7 && ctl == 2'd3;
    if (sel && xfer == 3'd2) m_a = zx(wdata, WA);
    if (sel && xfer == 3'd4) m_b = zx(wdata, WB);
    if (sel && xfer == 3'd6) m_c = zx(wdata, WC);
    b = m_busy; d = m_done; s = m_dis;
    if (wd && m_busy) begin b = 0; d = 1; end
    if (sel && xfer != 3'd7 && ctl == 2'd1) begin b = 1; d = 0; end
    if (sel && xfer != 3'd7 && ctl == 2'd2) begin b = 0; d = 0; end
    if (mask) s = wdata[MB];
    if (iores) begin b = 0; d = 0; s = 0; end
    m_busy = b; m_done = d; m_dis = s;
    m_irq = d && !s;
  endtask

  task automatic compare();
    chk("R3/R4/R6 busy", busy, m_busy);
    chk("R6 done", done, m_done);
    chk("R8 irq", irq, m_irq);
    chk("R10 rd_data", rdata, m_rd);
    chk("R11 skip", skip, m_skip);
    chk("R5 pulse", pulse, m_pulse);
    chk("R12 pri_out", pout, pin && !m_irq);
    chk("R7 exclusive", busy && done, 1'b0);
  endtask

  task automatic tick();
    @(posedge clk);
    model();
    #5;
    compare();
    @(negedge clk);
  endtask

  task automatic idle();
    rst = 0; iores = 0; iv = 0; mask = 0; iack = 0; pin = 0; wd = 0;
    idev = '0; xfer = '0; ctl = '0; wdata = '0;
  endtask

  task automatic op(logic [CW-1:0] dv, logic [2:0] x, logic [1:0] c, logic [DW-1:0] d);
    idle(); iv = 1; idev = dv; xfer = x; ctl = c; wdata = d;
    tick();
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle(); rst = 1;
    @(negedge clk);
    tick(); tick();
    // R1: reset state
    chk("R1 reset busy", busy, 0); chk("R1 reset done", done, 0);
    chk("R1 reset rd_data", rdata, 0);
    idle();
    // R10: write A then read back; R3 start applied in the same instruction
    op(CODE, 3'd2, 2'd1, 16'hBEEF);
    chk("R3 start with write", busy, 1);
    op(CODE, 3'd1, 2'd0, 16'h0);
    chk("R10 read A", rdata, 16'hBEEF);
    // R10: narrow buffer B zero-extends
    op(CODE, 3'd4, 2'd0, 16'h1234);
    op(CODE, 3'd3, 2'd0, 16'h0);
    chk("R10 read B zero-ext", rdata, 16'h0034);
    // R11: skip tests while busy; control ignored on skip
    op(CODE, 3'd7, 2'd0, 0); chk("R11 skip busy=1", skip, 1);
    op(CODE, 3'd7, 2'd2, 0); chk("R11 skip done=1", skip, 0);
    chk("R11 no control on skip", busy, 1);
    // R2: foreign and reserved codes ignored
    op(6'd0, 3'd2, 2'd2, 16'hFFFF);
    op(6'd63, 3'd4, 2'd2, 16'hFFFF);
    op(6'd18, 3'd6, 2'd2, 16'hFFFF);
    chk("R2 flags untouched", busy, 1);
    op(CODE, 3'd1, 2'd0, 0); chk("R2 buffer A untouched", rdata, 16'hBEEF);
    // R6: work done while busy
    idle(); wd = 1; tick();
    chk("R6 done set", done, 1); chk("R8 irq raised", irq, 1);
    // R12: acknowledge with priority, colliding with a read
    idle(); iack = 1; pin = 1; iv = 1; idev = CODE; xfer = 3'd1; tick();
    chk("R12 ack code", rdata, 16'(CODE));
    idle(); iack = 1; pin = 0; tick();
    chk("R12 no priority no code", rdata, 0);
    // R9: mask disables request
    idle(); mask = 1; wdata = 16'(1 << MB); tick();
    chk("R9 masked irq", irq, 0);
    idle(); mask = 1; wdata = ~16'(1 << MB); tick();
    chk("R9 unmasked irq", irq, 1);
    // R5: pulse
    op(CODE, 3'd0, 2'd3, 0); chk("R5 pulse", pulse, 1); chk("R5 flags kept", done, 1);
    // R6: work done while idle ignored; bus clear wins over work done
    op(CODE, 3'd0, 2'd2, 0); chk("R4 clear", done, 0);
    idle(); wd = 1; tick(); chk("R6 ignored when idle", done, 0);
    op(CODE, 3'd0, 2'd1, 0);
    idle(); wd = 1; iv = 1; idev = CODE; ctl = 2'd2; tick();
    chk("R6 clear beats done", done, 0);
    // R1: io reset
    op(CODE, 3'd0, 2'd1, 0);
    idle(); iores = 1; iv = 1; idev = CODE; ctl = 2'd1; tick();
    chk("R1 io reset wins", busy, 0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      idle();
      iv = ($urandom % 4) != 0;
      case ($urandom % 8)
        0: idev = 6'd0;
        1: idev = 6'd63;
        2: idev = 6'($urandom);
        default: idev = CODE;
      endcase
      xfer  = 3'($urandom);
      ctl   = ($urandom % 3 == 0) ? 2'd1 : 2'($urandom);
      wdata = 16'($urandom);
      wd    = ($urandom % 3) == 0;
      mask  = ($urandom % 10) == 0;
      iack  = ($urandom % 5) == 0;
      pin   = 1'($urandom);
      iores = ($urandom % 50) == 0;
      tick();
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule